// File: doc/BRIEF.md
# Fixed-Point Matrix-Vector Transform Unit

This unit computes `M * V + T * 4096` for one selectable 3x3 matrix of signed 16-bit entries and one selectable three-element signed 16-bit vector. It adds a selectable signed 32-bit translation, pre-scaled by 2^12. For each of the three rows it produces a 44-bit accumulator value and a 16-bit result clamped to a signed range. It also reports per-row overflow and clamp flags, an invalid-command flag, and an error summary.

Operands live in a small register file loaded through a single write port. A command gives a matrix selector, a vector selector, a translation selector, a shift bit and a clamp-floor bit, and is started with a one-cycle `start` pulse. The unit then works one row per cycle and raises `done` for one cycle when all three rows are stored. Results stay on the outputs until the next accepted command.

Top module: `mvx_unit`

## Requirements
- R1: After reset, `done` and `busy` are 0, every `acc_o` and `ir_o` lane is 0, and every flag output and `err_o` is 0.
- R2: `sel_mat` picks the matrix: code 0 is write addresses 0-8, code 1 is 9-17 and code 2 is 18-26. Entries are row-major, so the entry for row r and column c sits at base+3r+c. Code 3 uses an all-zero matrix and sets `inval_o` for that command; codes 0-2 clear it.
- R3: `sel_vec` codes 0, 1 and 2 pick the vector at addresses 27-29, 30-32 and 33-35, listed as x, y, z. Code 3 instead uses the three `ir_o` values present when the command is accepted, with lane 0 as x.
- R4: `sel_tr` codes 0, 1 and 2 pick the 32-bit translation at addresses 36-38, 39-41 and 42-44, indexed by row. Code 3 is a zero translation. The translation enters the row sum multiplied by 4096.
- R5: Row r is formed in a fixed order: the product M[r][0]*x, then plus M[r][1]*y, then plus M[r][2]*z, then plus the translation term. Each addition wraps to 44-bit two's complement. If any addition of a row leaves the signed 44-bit range, bit r of `ovf_o` is set.
- R6: With `shift_en`=1 the stored `acc_o` lane is the wrapped sum arithmetically shifted right by 12. With `shift_en`=0 it is the wrapped sum unchanged.
- R7: `ir_o` lane r is `acc_o` lane r clamped to [-32768, 32767]. When `clamp_pos`=1 the range is [0, 32767] instead. Bit r of `sat_o` is set exactly when clamping changed the value.
- R8: `err_o` is the OR of `ovf_o`, `sat_o` and `inval_o`. All flags are cleared when a command is accepted, so each command reports only its own flags.
- R9: A `start` sampled at clock edge E while idle is accepted. Rows 0, 1 and 2 are stored at edges E+1, E+2 and E+3. `done` is high for exactly the cycle after E+3. A `start` seen while busy is ignored, and outputs hold until the next accepted command.
- R10: A write with `wr_en`=1 at address A stores into the operand map above. Matrix and vector entries take `wr_data[15:0]` as signed; translations take all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Operand write strobe |
| wr_addr | input | 6 | Operand address (0-44) |
| wr_data | input | 32 | Operand write data |
| start | input | 1 | Command strobe |
| sel_mat | input | 2 | Matrix selector |
| sel_vec | input | 2 | Vector selector |
| sel_tr | input | 2 | Translation selector |
| shift_en | input | 1 | Shift results right by 12 |
| clamp_pos | input | 1 | Clamp floor of 0 instead of -32768 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_o | output | 3x44 | Per-row accumulator results |
| ir_o | output | 3x16 | Per-row clamped results |
| ovf_o | output | 3 | Per-row 44-bit overflow flags |
| sat_o | output | 3 | Per-row clamp flags |
| inval_o | output | 1 | Reserved matrix selector used |
| err_o | output | 1 | OR of all flags |

## Verification
A wrong latched selector or a wrong row counter shows up as a wrong `acc_o` lane. It is visible on the `done` cycle, three cycles after the accepted start. A stale vector latch appears only when selector code 3 reuses the previous `ir_o`, so the bench chains commands through that path. A flag that was not cleared, or a start accepted while busy, shows up as a wrong flag or as an extra `done` pulse on the following command.

// File: rtl/mvx_unit.sv
module mvx_unit #(
  parameter int DW   = 16,
  parameter int TW   = 32,
  parameter int AW   = 44,
  parameter int FRAC = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [5:0]           wr_addr,
  input  logic [TW-1:0]        wr_data,
  input  logic                 start,
  input  logic [1:0]           sel_mat,
  input  logic [1:0]           sel_vec,
  input  logic [1:0]           sel_tr,
  input  logic                 shift_en,
  input  logic                 clamp_pos,
  output logic                 busy,
  output logic                 done,
  output logic [2:0][AW-1:0]   acc_o,
  output logic [2:0][DW-1:0]   ir_o,
  output logic [2:0]           ovf_o,
  output logic [2:0]           sat_o,
  output logic                 inval_o,
  output logic                 err_o
);
  localparam int NM = 27;
  localparam int NV = 9;

  logic signed [DW-1:0] mat [NM];
  logic signed [DW-1:0] vec [NV];
  logic signed [TW-1:0] trn [NV];

  logic [1:0] mat_q, tr_q, row;
  logic       sf_q, lm_q;
  logic signed [DW-1:0] vq [3];

  logic [5:0] vaddr, taddr;
  assign vaddr = wr_addr - 6'd27;
  assign taddr = wr_addr - 6'd36;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NM; i++) mat[i] <= '0;
      for (int i = 0; i < NV; i++) begin
        vec[i] <= '0;
        trn[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr < 6'd27)      mat[wr_addr[4:0]] <= wr_data[DW-1:0];
      else if (wr_addr < 6'd36) vec[vaddr[3:0]]   <= wr_data[DW-1:0];
      else if (wr_addr < 6'd45) trn[taddr[3:0]]   <= wr_data;
    end
  end

  logic [4:0] mbase;
  logic [3:0] tidx;
  logic signed [DW-1:0]   m [3];
  logic signed [TW-1:0]   t;
  logic signed [2*DW-1:0] p [3];
  logic signed [AW:0]     s1, s2, s3, tsh;
  logic signed [AW-1:0]   a2, a3, a4, res;
  logic signed [AW-1:0]   hi, lo;
  logic                   row_ov, row_sat;
  logic [DW-1:0]          row_ir;

  always_comb begin
    mbase = 5'(mat_q) * 5'd9 + 5'(row) * 5'd3;
    tidx  = 4'(tr_q) * 4'd3 + 4'(row);
    for (int k = 0; k < 3; k++) begin
      m[k] = (mat_q == 2'd3) ? '0 : mat[mbase + 5'(k)];
      p[k] = m[k] * vq[k];
    end
    t   = (tr_q == 2'd3) ? '0 : trn[tidx];
    tsh = (AW+1)'(t) <<< FRAC;
    s1  = (AW+1)'(p[0]) + (AW+1)'(p[1]);
    a2  = s1[AW-1:0];
    s2  = {a2[AW-1], a2} + (AW+1)'(p[2]);
    a3  = s2[AW-1:0];
    s3  = {a3[AW-1], a3} + tsh;
    a4  = s3[AW-1:0];
    row_ov = (s1[AW] ^ s1[AW-1]) | (s2[AW] ^ s2[AW-1]) | (s3[AW] ^ s3[AW-1]);
    res = sf_q ? (a4 >>> FRAC) : a4;
    hi  = AW'((1 << (DW-1)) - 1);
    lo  = lm_q ? '0 : -hi - 1;
    if (res > hi) begin
      row_ir = hi[DW-1:0]; row_sat = 1'b1;
    end else if (res < lo) begin
      row_ir = lo[DW-1:0]; row_sat = 1'b1;
    end else begin
      row_ir = res[DW-1:0]; row_sat = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; row <= '0;
      mat_q <= '0; tr_q <= '0; sf_q <= 1'b0; lm_q <= 1'b0;
      for (int i = 0; i < 3; i++) vq[i] <= '0;
      acc_o <= '0; ir_o <= '0; ovf_o <= '0; sat_o <= '0; inval_o <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; row <= '0;
        mat_q <= sel_mat; tr_q <= sel_tr; sf_q <= shift_en; lm_q <= clamp_pos;
        for (int i = 0; i < 3; i++)
          vq[i] <= (sel_vec == 2'd3) ? ir_o[i] : vec[4'(sel_vec) * 4'd3 + 4'(i)];
        ovf_o <= '0; sat_o <= '0;
        inval_o <= (sel_mat == 2'd3);
      end else if (busy) begin
        acc_o[row] <= res;
        ir_o[row]  <= row_ir;
        ovf_o[row] <= row_ov;
        sat_o[row] <= row_sat;
        row <= row + 2'd1;
        if (row == 2'd2) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign err_o = |{ovf_o, sat_o, inval_o};

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (ovf_o == 3'b000 && sat_o == 3'b000));

  // R7
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lm_q) |-> (!ir_o[0][DW-1] && !ir_o[1][DW-1] && !ir_o[2][DW-1]));

  // R7
  sat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sat_o[0]) |-> (ir_o[0] == 16'h7fff || ir_o[0] == 16'h8000 || ir_o[0] == 16'h0000));
endmodule

// File: tb/mvx_unit_tb.sv
`timescale 1ns/1ps
module mvx_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [5:0] wr_addr = '0; logic [31:0] wr_data = '0;
  logic start = 1'b0; logic [1:0] sel_mat = '0, sel_vec = '0, sel_tr = '0;
  logic shift_en = 1'b0, clamp_pos = 1'b0;
  logic busy, done, inval_o, err_o;
  logic [2:0][43:0] acc_o; logic [2:0][15:0] ir_o;
  logic [2:0] ovf_o, sat_o;

  mvx_unit dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .sel_mat(sel_mat), .sel_vec(sel_vec), .sel_tr(sel_tr), .shift_en(shift_en),
    .clamp_pos(clamp_pos), .busy(busy), .done(done), .acc_o(acc_o), .ir_o(ir_o),
    .ovf_o(ovf_o), .sat_o(sat_o), .inval_o(inval_o), .err_o(err_o));

  always #4 clk = ~clk;

  typedef struct packed {
    logic [2:0][43:0] mac; logic [2:0][15:0] ir;
    logic [2:0] ov; logic [2:0] sat; logic inv; logic [31:0] t0;
  } exp_t;

  exp_t q[$]; string tq[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  shortint bmat[27]; shortint bvec[9]; int btr[9]; int ir_last[3];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic longint w44(longint x, inout bit ov);
    longint y; y = (x <<< 20) >>> 20;
    if (y != x) ov = 1'b1;
    return y;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
    if (a < 27) bmat[a] = shortint'(d[15:0]);
    else if (a < 36) bvec[a-27] = shortint'(d[15:0]);
    else btr[a-36] = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cmd(string tag, int m, int v, int t, bit sf, bit lm, bit poke);
    exp_t e; longint vv[3];
    e = '0;
    for (int i = 0; i < 3; i++) vv[i] = (v == 3) ? longint'(ir_last[i]) : longint'(bvec[v*3+i]);
    for (int r = 0; r < 3; r++) begin
      longint mm[3]; longint a; bit ov; longint tt; int irv; bit st;
      ov = 1'b0;
      for (int k = 0; k < 3; k++) mm[k] = (m == 3) ? 0 : longint'(bmat[m*9 + r*3 + k]);
      tt = (t == 3) ? 0 : longint'(btr[t*3 + r]);
      a = mm[0] * vv[0];
      a = w44(a + mm[1] * vv[1], ov);
      a = w44(a + mm[2] * vv[2], ov);
      a = w44(a + tt * 4096, ov);
      if (sf) a = a >>> 12;
      st = 1'b0;
      if (a > 32767) begin irv = 32767; st = 1'b1; end
      else if (a < (lm ? 0 : -32768)) begin irv = lm ? 0 : -32768; st = 1'b1; end
      else irv = int'(a);
      e.mac[r] = a[43:0]; e.ir[r] = irv[15:0]; e.ov[r] = ov; e.sat[r] = st;
      ir_last[r] = irv;
    end
    e.inv = (m == 3);
    @(negedge clk);
    sel_mat = 2'(m); sel_vec = 2'(v); sel_tr = 2'(t); shift_en = sf; clamp_pos = lm; start = 1'b1;
    e.t0 = cyc; q.push_back(e); tq.push_back(tag);
    @(negedge clk); start = 1'b0;
    if (poke) begin
      sel_mat = 2'd3; sel_vec = 2'd1; sel_tr = 2'd2; shift_en = ~sf; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk("R9 unexpected done", 1, 0);
      else begin
        exp_t e; string tg;
        e = q.pop_front(); tg = tq.pop_front();
        chk({tg, " R9 latency"}, cyc - e.t0, 4);
        for (int r = 0; r < 3; r++) begin
          chk({tg, " R5 acc"}, longint'(acc_o[r]), longint'(e.mac[r]));
          chk({tg, " R7 ir"}, longint'(ir_o[r]), longint'(e.ir[r]));
        end
        chk({tg, " R5 ovf"}, ovf_o, e.ov);
        chk({tg, " R7 sat"}, sat_o, e.sat);
        chk({tg, " R2 inval"}, inval_o, e.inv);
        chk({tg, " R8 err"}, err_o, |{e.ov, e.sat, e.inv});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=0 exp=1");
    summary();
  end

  initial begin
    for (int i = 0; i < 27; i++) bmat[i] = 0;
    for (int i = 0; i < 9; i++) begin bvec[i] = 0; btr[i] = 0; end
    for (int i = 0; i < 3; i++) ir_last[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", done, 0); chk("R1 busy", busy, 0); chk("R1 err", err_o, 0);
    chk("R1 flags", {ovf_o, sat_o, inval_o}, 0);
    for (int r = 0; r < 3; r++) begin
      chk("R1 acc", longint'(acc_o[r]), 0); chk("R1 ir", longint'(ir_o[r]), 0);
    end
    // R10 loading: rotation matrix diagonal 4096, V0, translation
    for (int i = 0; i < 9; i++) wr(i, (i % 4 == 0) ? 4096 : 0);
    wr(27, 100); wr(28, -200); wr(29, 300);
    wr(36, 1); wr(37, 2); wr(38, 3);
    cmd("R2 R4 R6 mat0", 0, 0, 0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 9; i++) wr(9 + i, i * 731 - 3000);
    wr(30, 1234); wr(31, -567); wr(32, 89);
    wr(39, -5000); wr(40, 70000); wr(41, 123);
    cmd("R2 R3 R4 mat1", 1, 1, 1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 9; i++) wr(18 + i, -(i * 500 + 100));
    wr(33, 300); wr(34, 400); wr(35, -500);
    wr(42, 10); wr(43, -20); wr(44, 30);
    cmd("R2 R3 R7 mat2 floor", 2, 2, 2, 1'b1, 1'b1, 1'b0);
    cmd("R2 R6 sf0", 2, 2, 2, 1'b0, 1'b0, 1'b0);
    cmd("R3 R4 ir reuse zero tr", 0, 3, 3, 1'b1, 1'b0, 1'b0);
    // R5 overflow: row0 positive, row1 negative
    for (int i = 0; i < 9; i++) wr(i, 0);
    wr(0, 1); wr(4, -1); wr(8, 1);
    wr(27, 4096); wr(28, 4096); wr(29, 5);
    wr(36, 32'h7fffffff); wr(37, 32'h80000000); wr(38, 0);
    cmd("R5 overflow", 0, 0, 0, 1'b0, 1'b0, 1'b0);
    cmd("R8 flags cleared", 1, 1, 1, 1'b1, 1'b0, 1'b0);
    cmd("R2 reserved matrix", 3, 0, 2, 1'b0, 1'b0, 1'b0);
    cmd("R9 start while busy ignored", 0, 2, 1, 1'b1, 1'b0, 1'b1);
    begin
      logic [2:0][15:0] held; held = ir_o;
      repeat (6) @(negedge clk);
      chk("R9 outputs hold", longint'(ir_o), longint'(held));
      chk("R9 no extra done", q.size(), 0);
    end
    summary();
  end
endmodule